// File: doc/BRIEF.md
# Full-Device Erase Unlock Sequence Detector

This block watches decoded write transactions from a bus front end. Each transaction carries an address, a data byte and a valid strobe. The block looks for a fixed series of six writes that unlocks a whole-device erase. When the sixth write matches, it sends a single-cycle start pulse to the internal erase controller.

Each step of the series is a particular data byte written to one of two fixed addresses. Only the lower fifteen address bits are compared. A write that breaks the series throws away the progress made so far. While the erase controller reports busy, the detector stays at its idle step and takes no notice of writes.

The six steps, in the order they must arrive (address in the low 15 bits, then data):

| Step | Address | Data |
|---|---|---|
| 1 | 0x5555 | 0xAA |
| 2 | 0x2AAA | 0x55 |
| 3 | 0x5555 | 0x80 |
| 4 | 0x5555 | 0xAA |
| 5 | 0x2AAA | 0x55 |
| 6 | 0x5555 | 0x10 |

Top module: `erase_seq_detect`

## Requirements
- R1: After reset, `eraseStart` is 0 and the detector is at its idle step, so a complete series is needed before any pulse.
- R2: When the six steps in the table above arrive in order, `eraseStart` is 1 for exactly one cycle. That cycle is the one after the clock edge that accepts the sixth write.
- R3: Address bit 15 takes no part in the match. Bits 14:0 must equal the step's address exactly.
- R4: A valid write that matches neither the expected step nor step 1 returns the detector to the idle step. The whole series must then be sent again from step 1.
- R5: A wrong write that is itself 0xAA to 0x5555 counts as step 1 of a new series.
- R6: While `eraseBusy` is 1, writes are ignored and the detector goes back to the idle step. A series interrupted by busy never produces a pulse.
- R7: Cycles with `wrValid` at 0 do not change the progress of the series.
- R8: After a pulse, the detector is back at the idle step. A second pulse needs a new complete series of six writes.
- R9: A series that stops after five or fewer matching steps never produces a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| wrValid | input | 1 | A decoded write is present this cycle |
| wrAddr | input | 16 | Write address |
| wrData | input | 8 | Write data |
| eraseBusy | input | 1 | The erase controller is busy |
| eraseStart | output | 1 | One-cycle request to start the full-device erase |

## Verification
The series is sent in several ways:
- plain and back to back, which tells a correct one-cycle pulse apart from a stuck or repeated one;
- with bit 15 set and with a bit below 15 cleared, which separates the don't-care bit from the compared bits;
- with wrong data at a middle step, and with a stray 0xAA to 0x5555 in the middle, which tell a full restart apart from a restart that re-enters at step 1;
- with idle cycles between writes, with busy raised partway through, and with busy held during the final write, which show that gaps keep the progress while busy clears it.

A behavioural model in the bench keeps its own step count and predicts the pulse for every cycle.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;

  localparam int SEQ_LEN = 6;

  typedef struct packed {
    logic clear;
    logic advance;
    logic loadFirst;
  } seqStrobe_t;

  function automatic logic [14:0] stepAddr(input int idx);
    case (idx)
      1, 4:    stepAddr = 15'h2AAA;
      default: stepAddr = 15'h5555;
    endcase
  endfunction

  function automatic logic [7:0] stepData(input int idx);
    case (idx)
      0, 3:    stepData = 8'hAA;
      1, 4:    stepData = 8'h55;
      2:       stepData = 8'h80;
      default: stepData = 8'h10;
    endcase
  endfunction

endpackage

// File: rtl/erase_seq_dp.sv
module erase_seq_dp
  import erase_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CMP_W  = 15,
  parameter int DATA_W = 8,
  parameter int STEP_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  seqStrobe_t        strobe,
  output logic              matchCur,
  output logic              matchFirst,
  output logic              atLast,
  output logic [STEP_W-1:0] stepQ
);

  localparam int VEC_W = 2 ** STEP_W;

  logic [VEC_W-1:0] matchVec;
  logic [CMP_W-1:0] cmpAddr;

  assign cmpAddr = wrAddr[CMP_W-1:0];

  for (genvar i = 0; i < VEC_W; i++) begin : g_step
    if (i < SEQ_LEN) begin : g_real
      assign matchVec[i] = (cmpAddr == CMP_W'(stepAddr(i))) &&
                           (wrData == DATA_W'(stepData(i)));
    end else begin : g_pad
      assign matchVec[i] = 1'b0;
    end
  end

  assign matchCur   = matchVec[stepQ];
  assign matchFirst = matchVec[0];
  assign atLast     = (stepQ == STEP_W'(SEQ_LEN - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 stepQ <= '0;
    else if (strobe.clear)     stepQ <= '0;
    else if (strobe.advance)   stepQ <= stepQ + STEP_W'(1);
    else if (strobe.loadFirst) stepQ <= STEP_W'(1);
  end

endmodule

// File: rtl/erase_seq_ctl.sv
module erase_seq_ctl
  import erase_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrValid,
  input  logic       eraseBusy,
  input  logic       matchCur,
  input  logic       matchFirst,
  input  logic       atLast,
  output seqStrobe_t strobe,
  output logic       eraseStart
);

  logic accept;
  logic fire;

  assign accept = wrValid && !eraseBusy;
  assign fire   = accept && matchCur && atLast;

  always_comb begin
    strobe.clear     = eraseBusy || fire ||
                       (accept && !matchCur && !matchFirst);
    strobe.advance   = accept && matchCur && !atLast;
    strobe.loadFirst = accept && !matchCur && matchFirst;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) eraseStart <= 1'b0;
    else       eraseStart <= fire;
  end

endmodule

// File: rtl/erase_seq_detect.sv
module erase_seq_detect
  import erase_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CMP_W  = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              eraseBusy,
  output logic              eraseStart
);

  localparam int STEP_W = $clog2(SEQ_LEN);

  seqStrobe_t        strobe;
  logic              matchCur;
  logic              matchFirst;
  logic              atLast;
  logic [STEP_W-1:0] stepQ;

  erase_seq_dp #(
    .ADDR_W(ADDR_W), .CMP_W(CMP_W), .DATA_W(DATA_W), .STEP_W(STEP_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .wrAddr(wrAddr), .wrData(wrData),
    .strobe(strobe), .matchCur(matchCur), .matchFirst(matchFirst),
    .atLast(atLast), .stepQ(stepQ)
  );

  erase_seq_ctl ctl_i (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .eraseBusy(eraseBusy),
    .matchCur(matchCur), .matchFirst(matchFirst), .atLast(atLast),
    .strobe(strobe), .eraseStart(eraseStart)
  );

endmodule

// File: rtl/erase_seq_checker.sv
module erase_seq_checker #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int STEP_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrValid,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic              eraseBusy,
  input logic              eraseStart,
  input logic [STEP_W-1:0] stepQ
);

  // R2: the start request lasts a single cycle
  p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    eraseStart |=> !eraseStart);

  // R2: a pulse follows an accepted final write of 0x10
  p_pulse_cause_r2: assert property (@(posedge clk) disable iff (!rstN)
    eraseStart |-> $past(wrValid && !eraseBusy && wrData == 8'h10));

  // R3: the final write hit 0x5555 in the compared bits
  p_pulse_addr_r3: assert property (@(posedge clk) disable iff (!rstN)
    eraseStart |-> $past(wrAddr[14:0]) == 15'h5555);

  // R6: busy leaves the detector idle and blocks a pulse
  p_busy_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    eraseBusy |=> (stepQ == '0) && !eraseStart);

  // R7: no write, no busy: progress is kept
  p_gap_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!wrValid && !eraseBusy) |=> $stable(stepQ));

  // R8: a pulse leaves the detector at the idle step
  p_pulse_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    eraseStart |-> stepQ == '0);

endmodule

bind erase_seq_detect erase_seq_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STEP_W(STEP_W)
) chk_i (
  .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrAddr(wrAddr),
  .wrData(wrData), .eraseBusy(eraseBusy), .eraseStart(eraseStart),
  .stepQ(stepQ)
);

// File: tb/erase_seq_detect_tb.sv
module erase_seq_detect_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrValid = 1'b0;
  logic [15:0] wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic        eraseBusy = 1'b0;
  logic        eraseStart;

  int checks = 0;
  int fails = 0;
  int refStep = 0;
  bit refPulse = 1'b0;
  bit done = 1'b0;
  string req = "R1";
  int seqA[6] = '{16'h5555, 16'h2AAA, 16'h5555, 16'h5555, 16'h2AAA, 16'h5555};
  int seqD[6] = '{8'hAA, 8'h55, 8'h80, 8'hAA, 8'h55, 8'h10};
  int pulses = 0;

  always #10 clk = ~clk;

  erase_seq_detect dut_i (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrAddr(wrAddr),
    .wrData(wrData), .eraseBusy(eraseBusy), .eraseStart(eraseStart)
  );

  function automatic bit isStep(int idx, logic [15:0] a, logic [7:0] d);
    return (a[14:0] == 15'(seqA[idx])) && (d == 8'(seqD[idx]));
  endfunction

  task automatic check(string tag, bit act, bit exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s eraseStart=%0b expected %0b", tag, act, exp);
    end
  endtask

  // one clock: drive at negedge, model at posedge, compare at next negedge
  task automatic cyc(bit v, logic [15:0] a, logic [7:0] d, bit b);
    wrValid = v; wrAddr = a; wrData = d; eraseBusy = b;
    @(posedge clk);
    refPulse = 1'b0;
    if (b) refStep = 0;
    else if (v) begin
      if (isStep(refStep, a, d)) begin
        if (refStep == 5) begin refStep = 0; refPulse = 1'b1; end
        else refStep++;
      end else if (isStep(0, a, d)) refStep = 1;
      else refStep = 0;
    end
    @(negedge clk);
    if (refPulse) pulses++;
    check(req, eraseStart, refPulse);
  endtask

  task automatic wr(int idx, logic [15:0] hiMask = 16'h0);
    cyc(1'b1, 16'(seqA[idx]) | hiMask, 8'(seqD[idx]), 1'b0);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 16'h0, 8'h0, 1'b0);
  endtask

  task automatic full();
    for (int i = 0; i < 6; i++) wr(i);
  endtask

  task automatic expectPulses(string tag, int exp);
    checks++;
    if (pulses != exp) begin
      fails++;
      $display("FAIL %s pulses=%0d expected %0d", tag, pulses, exp);
    end
    pulses = 0;
  endtask

  initial begin
    #4000000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog run did not end");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    req = "R1"; check("R1 in reset", eraseStart, 1'b0);
    rstN = 1'b1;
    idle(2);
    for (int i = 1; i < 6; i++) wr(i);   // steps 2..6 from idle: no pulse
    expectPulses("R1", 0);

    req = "R2"; full(); idle(2); expectPulses("R2", 1);

    req = "R3"; for (int i = 0; i < 6; i++) wr(i, 16'h8000);
    idle(1); expectPulses("R3 bit15 ignored", 1);
    for (int i = 0; i < 5; i++) wr(i);
    cyc(1'b1, 16'h1555, 8'h10, 1'b0); idle(1);
    expectPulses("R3 bit14 compared", 0);

    req = "R4"; wr(0); wr(1); wr(2);
    cyc(1'b1, 16'h5555, 8'h55, 1'b0);
    wr(4); wr(5); idle(1); expectPulses("R4 broken", 0);
    full(); idle(1); expectPulses("R4 retry", 1);

    req = "R5"; wr(0); wr(1); wr(0);
    for (int i = 1; i < 6; i++) wr(i);
    idle(1); expectPulses("R5 reenter", 1);

    req = "R6"; wr(0); wr(1); wr(2);
    cyc(1'b1, 16'h5555, 8'hAA, 1'b1);
    wr(4); wr(5); idle(1); expectPulses("R6 busy mid", 0);
    for (int i = 0; i < 5; i++) wr(i);
    cyc(1'b1, 16'h5555, 8'h10, 1'b1); idle(1);
    expectPulses("R6 busy last", 0);
    for (int i = 0; i < 3; i++) wr(i);
    cyc(1'b0, 16'h0, 8'h0, 1'b1);
    for (int i = 3; i < 6; i++) wr(i);
    idle(1); expectPulses("R6 busy idle", 0);

    req = "R7"; for (int i = 0; i < 6; i++) begin wr(i); idle(i + 1); end
    expectPulses("R7 gaps", 1);

    req = "R8"; full(); full(); idle(1); expectPulses("R8 back to back", 2);
    full(); for (int i = 1; i < 6; i++) wr(i); idle(1);
    expectPulses("R8 restart needed", 1);

    req = "R9"; for (int i = 0; i < 5; i++) wr(i); idle(3);
    expectPulses("R9 partial", 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule